// File: doc/BRIEF.md
# Transmit Stream Pairing Demultiplexer

This block sits on the transmit side of a multichannel DMA engine and fans its traffic out to several Ethernet MAC transmit ports. The DMA presents two shared AXI4-Stream inputs. The data stream tags each packet with a destination channel on TDEST. The control stream carries sideband frames with no channel tag at all. The block infers the channel of each control frame from the data packet it is paired with. It then forwards the pair to the per-port control and data outputs of that channel.

Pairing follows arrival order. The n-th control frame, closed by TLAST, belongs to the n-th data packet, also closed by TLAST. Either half may show up first, so the block holds back both inputs until it knows the destination. It forwards the complete control frame, and only after that the data packet. Packets that name a channel the block does not implement are absorbed together with their control frame, and nothing reaches any port.

Top module: `tx_pair_demux`

## Requirements
- R1: While reset is high and in the first cycle after it, every output TVALID is low and both input TREADY signals are low. Reset is synchronous and active-high.
- R2: A data packet whose first-beat TDEST is d, with d below NPORTS, appears only on data output port d. Its TDATA and TLAST are unchanged and its beat order is kept. No other port's data TVALID rises.
- R3: The control frame paired with a packet appears only on the control output of the same port d, with its TDATA and TLAST unchanged.
- R4: On a port, every beat of the paired control frame, up to and including its TLAST beat, is accepted before that port's first data beat of the pair shows TVALID.
- R5: A control frame that arrives before its data packet is held, with control TREADY low, until a data beat is valid. A data packet that arrives before its control frame is held, with data TREADY low, until that frame has been fully passed on.
- R6: The port is chosen from TDEST of the first data beat only. TDEST on later beats of the same packet has no effect on where the beats go.
- R7: A packet whose first-beat TDEST is NPORTS or above is consumed together with its paired control frame, and no output TVALID rises for either. The following pair is routed normally.
- R8: When the selected output holds TREADY low, the matching input sees TREADY low, and the output keeps TVALID high with TDATA stable until it is accepted.
- R9: Over a run of several pairs sent back to back, the k-th control frame always travels with the k-th data packet, whatever ports the packets name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_dat_tdata | input | DATA_W | Shared data stream payload |
| s_dat_tdest | input | DEST_W | Destination channel of the data packet |
| s_dat_tlast | input | 1 | Last beat of data packet |
| s_dat_tvalid | input | 1 | Data input valid |
| s_dat_tready | output | 1 | Data input ready |
| s_ctl_tdata | input | CTRL_W | Shared control stream payload |
| s_ctl_tlast | input | 1 | Last beat of control frame |
| s_ctl_tvalid | input | 1 | Control input valid |
| s_ctl_tready | output | 1 | Control input ready |
| m_dat_tdata | output | NPORTS*DATA_W | Per-port data payload, port i at bits i*DATA_W |
| m_dat_tlast | output | NPORTS | Per-port data last |
| m_dat_tvalid | output | NPORTS | Per-port data valid |
| m_dat_tready | input | NPORTS | Per-port data ready |
| m_ctl_tdata | output | NPORTS*CTRL_W | Per-port control payload, port i at bits i*CTRL_W |
| m_ctl_tlast | output | NPORTS | Per-port control last |
| m_ctl_tvalid | output | NPORTS | Per-port control valid |
| m_ctl_tready | input | NPORTS | Per-port control ready |

## Verification
The bench builds the block with NPORTS=4, DEST_W=4 and 32-bit data and control. The 4-bit destination field can then carry twelve channel numbers the block does not implement, which exercises the drop path next to real ports. Four ports are enough for back-to-back pairs to alternate between ports and revisit one, so a pairing that slips by one frame shows up as misrouted traffic. Multi-beat frames on both streams let the bench vary arrival order, change TDEST in the middle of a packet and stall an output partway through a packet.

// File: rtl/txpd_pkg.sv
package txpd_pkg;

    // Phase of the pairing sequence for the pair currently in flight
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,   // no destination known yet
        PH_CTL  = 2'd1,   // passing the control frame
        PH_DAT  = 2'd2    // passing the data packet
    } phase_e;

    // True when a destination code names an implemented port
    function automatic logic fn_dest_ok(input int unsigned dest, input int unsigned nports);
        return dest < nports;
    endfunction

endpackage

// File: rtl/txpd_pair_ctrl.sv
module txpd_pair_ctrl
    import txpd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_peek_valid,
    input  logic [DEST_W-1:0] dat_peek_dest,
    input  logic              ctl_done,
    input  logic              dat_done,
    output phase_e            phase,
    output logic [DEST_W-1:0] sel,
    output logic              drop
);

    phase_e            phase_q;
    logic [DEST_W-1:0] sel_q;
    logic              drop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAIT;
            sel_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_WAIT: begin
                    if (dat_peek_valid) begin
                        sel_q   <= dat_peek_dest;
                        drop_q  <= !fn_dest_ok(int'(dat_peek_dest), NPORTS);
                        phase_q <= PH_CTL;
                    end
                end
                PH_CTL: begin
                    if (ctl_done) phase_q <= PH_DAT;
                end
                PH_DAT: begin
                    if (dat_done) phase_q <= PH_WAIT;
                end
                default: phase_q <= PH_WAIT;
            endcase
        end
    end

    assign phase = phase_q;
    assign sel   = sel_q;
    assign drop  = drop_q;

    // R6: selection is frozen while a data packet is in flight
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DAT && !dat_done) |=> $stable(sel_q));

    // R4: a control phase never returns to idle without handing over to data
    p_ctl_then_dat_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CTL) |=> (phase_q != PH_WAIT));

endmodule

// File: rtl/txpd_steer.sv
module txpd_steer #(
    parameter int NPORTS = 4,
    parameter int W      = 32,
    parameter int SEL_W  = 4
) (
    input  logic              en,
    input  logic              drop,
    input  logic [SEL_W-1:0]  sel,
    input  logic [W-1:0]      s_tdata,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [NPORTS*W-1:0] m_tdata,
    output logic [NPORTS-1:0] m_tlast,
    output logic [NPORTS-1:0] m_tvalid,
    input  logic [NPORTS-1:0] m_tready
);

    logic sel_rdy;

    always_comb begin
        sel_rdy = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (sel == SEL_W'(i)) sel_rdy = m_tready[i];
        end
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign m_tdata[g*W +: W] = s_tdata;
        assign m_tlast[g]        = s_tlast;
        assign m_tvalid[g]       = en && !drop && s_tvalid && (sel == SEL_W'(g));
    end

    assign s_tready = en && (drop || sel_rdy);

endmodule

// File: rtl/tx_pair_demux.sv
module tx_pair_demux
    import txpd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 32,
    parameter int DEST_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DATA_W-1:0]        s_dat_tdata,
    input  logic [DEST_W-1:0]        s_dat_tdest,
    input  logic                     s_dat_tlast,
    input  logic                     s_dat_tvalid,
    output logic                     s_dat_tready,
    input  logic [CTRL_W-1:0]        s_ctl_tdata,
    input  logic                     s_ctl_tlast,
    input  logic                     s_ctl_tvalid,
    output logic                     s_ctl_tready,
    output logic [NPORTS*DATA_W-1:0] m_dat_tdata,
    output logic [NPORTS-1:0]        m_dat_tlast,
    output logic [NPORTS-1:0]        m_dat_tvalid,
    input  logic [NPORTS-1:0]        m_dat_tready,
    output logic [NPORTS*CTRL_W-1:0] m_ctl_tdata,
    output logic [NPORTS-1:0]        m_ctl_tlast,
    output logic [NPORTS-1:0]        m_ctl_tvalid,
    input  logic [NPORTS-1:0]        m_ctl_tready
);

    phase_e            phase;
    logic [DEST_W-1:0] sel;
    logic              drop;
    logic              ctl_done;
    logic              dat_done;

    assign ctl_done = s_ctl_tvalid && s_ctl_tready && s_ctl_tlast;
    assign dat_done = s_dat_tvalid && s_dat_tready && s_dat_tlast;

    txpd_pair_ctrl #(.NPORTS(NPORTS), .DEST_W(DEST_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .dat_peek_valid (s_dat_tvalid),
        .dat_peek_dest  (s_dat_tdest),
        .ctl_done       (ctl_done),
        .dat_done       (dat_done),
        .phase          (phase),
        .sel            (sel),
        .drop           (drop)
    );

    txpd_steer #(.NPORTS(NPORTS), .W(CTRL_W), .SEL_W(DEST_W)) u_ctl_steer (
        .en       (phase == PH_CTL),
        .drop     (drop),
        .sel      (sel),
        .s_tdata  (s_ctl_tdata),
        .s_tlast  (s_ctl_tlast),
        .s_tvalid (s_ctl_tvalid),
        .s_tready (s_ctl_tready),
        .m_tdata  (m_ctl_tdata),
        .m_tlast  (m_ctl_tlast),
        .m_tvalid (m_ctl_tvalid),
        .m_tready (m_ctl_tready)
    );

    txpd_steer #(.NPORTS(NPORTS), .W(DATA_W), .SEL_W(DEST_W)) u_dat_steer (
        .en       (phase == PH_DAT),
        .drop     (drop),
        .sel      (sel),
        .s_tdata  (s_dat_tdata),
        .s_tlast  (s_dat_tlast),
        .s_tvalid (s_dat_tvalid),
        .s_tready (s_dat_tready),
        .m_tdata  (m_dat_tdata),
        .m_tlast  (m_dat_tlast),
        .m_tvalid (m_dat_tvalid),
        .m_tready (m_dat_tready)
    );

    // R1: first cycle out of reset drives nothing
    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (m_dat_tvalid == '0 && m_ctl_tvalid == '0 && !s_dat_tready && !s_ctl_tready));

    // R2: at most one data port is offered a beat
    p_one_dat_port_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_dat_tvalid));

    // R3: at most one control port is offered a beat
    p_one_ctl_port_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_ctl_tvalid));

    // R4: control and data of a pair are never offered together
    p_ctl_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !((|m_dat_tvalid) && (|m_ctl_tvalid)));

    // R8: a stalled data beat stays offered on the same port
    p_dat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (|(m_dat_tvalid & ~m_dat_tready)) |=> (m_dat_tvalid == $past(m_dat_tvalid)));

endmodule

// File: tb/tx_pair_demux_tb.sv
`timescale 1ns/1ps
module tx_pair_demux_tb;

    localparam int NP = 4;
    localparam int DW = 32;
    localparam int CW = 32;
    localparam int TW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DW-1:0]     s_dat_tdata = '0;
    logic [TW-1:0]     s_dat_tdest = '0;
    logic              s_dat_tlast = 1'b0;
    logic              s_dat_tvalid = 1'b0;
    logic              s_dat_tready;
    logic [CW-1:0]     s_ctl_tdata = '0;
    logic              s_ctl_tlast = 1'b0;
    logic              s_ctl_tvalid = 1'b0;
    logic              s_ctl_tready;
    logic [NP*DW-1:0]  m_dat_tdata;
    logic [NP-1:0]     m_dat_tlast;
    logic [NP-1:0]     m_dat_tvalid;
    logic [NP-1:0]     m_dat_tready = '1;
    logic [NP*CW-1:0]  m_ctl_tdata;
    logic [NP-1:0]     m_ctl_tlast;
    logic [NP-1:0]     m_ctl_tvalid;
    logic [NP-1:0]     m_ctl_tready = '1;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // per-port log: {is_ctl, last, payload}
    logic [33:0] plog [NP][64];
    int          pcnt [NP];

    always #2 clk = ~clk;

    tx_pair_demux #(.NPORTS(NP), .DATA_W(DW), .CTRL_W(CW), .DEST_W(TW)) u_dut (
        .clk(clk), .rst(rst),
        .s_dat_tdata(s_dat_tdata), .s_dat_tdest(s_dat_tdest), .s_dat_tlast(s_dat_tlast),
        .s_dat_tvalid(s_dat_tvalid), .s_dat_tready(s_dat_tready),
        .s_ctl_tdata(s_ctl_tdata), .s_ctl_tlast(s_ctl_tlast),
        .s_ctl_tvalid(s_ctl_tvalid), .s_ctl_tready(s_ctl_tready),
        .m_dat_tdata(m_dat_tdata), .m_dat_tlast(m_dat_tlast),
        .m_dat_tvalid(m_dat_tvalid), .m_dat_tready(m_dat_tready),
        .m_ctl_tdata(m_ctl_tdata), .m_ctl_tlast(m_ctl_tlast),
        .m_ctl_tvalid(m_ctl_tvalid), .m_ctl_tready(m_ctl_tready)
    );

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (m_ctl_tvalid[p] && m_ctl_tready[p] && pcnt[p] < 64) begin
                    plog[p][pcnt[p]] = {1'b1, m_ctl_tlast[p], m_ctl_tdata[p*CW +: CW]};
                    pcnt[p] = pcnt[p] + 1;
                end
                if (m_dat_tvalid[p] && m_dat_tready[p] && pcnt[p] < 64) begin
                    plog[p][pcnt[p]] = {1'b0, m_dat_tlast[p], m_dat_tdata[p*DW +: DW]};
                    pcnt[p] = pcnt[p] + 1;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int p = 0; p < NP; p++) pcnt[p] = 0;
    endtask

    task automatic send_ctl(input logic [CW-1:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            s_ctl_tvalid = 1'b1;
            s_ctl_tdata  = base + CW'(i);
            s_ctl_tlast  = (i == n-1);
            @(negedge clk);
            while (!s_ctl_tready) @(negedge clk);
            @(posedge clk); #1;
        end
        s_ctl_tvalid = 1'b0;
        s_ctl_tlast  = 1'b0;
    endtask

    task automatic send_dat(input logic [TW-1:0] dest, input logic [DW-1:0] base, input int n,
                            input logic chg, input logic [TW-1:0] later_dest);
        for (int i = 0; i < n; i++) begin
            s_dat_tvalid = 1'b1;
            s_dat_tdata  = base + DW'(i);
            s_dat_tlast  = (i == n-1);
            s_dat_tdest  = (i > 0 && chg) ? later_dest : dest;
            @(negedge clk);
            while (!s_dat_tready) @(negedge clk);
            @(posedge clk); #1;
        end
        s_dat_tvalid = 1'b0;
        s_dat_tlast  = 1'b0;
    endtask

    // checks one pair in port p's log starting at pos
    task automatic expect_pair(input int p, input logic [CW-1:0] cb, input int cn,
                               input logic [DW-1:0] db, input int dn, input string req,
                               inout int pos);
        for (int i = 0; i < cn; i++) begin
            logic [33:0] e;
            e = {1'b1, (i == cn-1), cb + CW'(i)};
            chk(plog[p][pos] == e && pos < pcnt[p], req, longint'(plog[p][pos]), longint'(e));
            pos++;
        end
        for (int i = 0; i < dn; i++) begin
            logic [33:0] e;
            e = {1'b0, (i == dn-1), db + DW'(i)};
            chk(plog[p][pos] == e && pos < pcnt[p], req, longint'(plog[p][pos]), longint'(e));
            pos++;
        end
    endtask

    task automatic expect_count(input int p, input int n, input string req);
        chk(pcnt[p] == n, req, longint'(pcnt[p]), longint'(n));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        chk(m_dat_tvalid == '0 && m_ctl_tvalid == '0, "R1 valids in reset", {m_dat_tvalid, m_ctl_tvalid}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(m_dat_tvalid == '0 && m_ctl_tvalid == '0, "R1 valids after reset", {m_dat_tvalid, m_ctl_tvalid}, 0);
        chk(!s_dat_tready && !s_ctl_tready, "R1 readies after reset", {s_dat_tready, s_ctl_tready}, 0);
    endtask

    // R5 R3 R2 R4: control arrives first
    task automatic t_ctl_first();
        int pos = 0;
        clear_logs();
        fork
            send_ctl(32'hC100, 2);
            begin idle(6); send_dat(4'd1, 32'hD100, 3, 1'b0, 4'd0); end
            begin repeat (3) @(negedge clk);
                  chk(!s_ctl_tready, "R5 control held without data", s_ctl_tready, 0); end
        join
        idle(4);
        expect_pair(1, 32'hC100, 2, 32'hD100, 3, "R3 R4 ctl-first pair", pos);
        expect_count(0, 0, "R2 port0 silent");
        expect_count(2, 0, "R2 port2 silent");
        expect_count(3, 0, "R2 port3 silent");
    endtask

    // R5 R4: data arrives first
    task automatic t_dat_first();
        int pos = 0;
        clear_logs();
        fork
            send_dat(4'd2, 32'hD200, 4, 1'b0, 4'd0);
            begin idle(6); send_ctl(32'hC200, 3); end
            begin repeat (4) @(negedge clk);
                  chk(!s_dat_tready, "R5 data held without control", s_dat_tready, 0); end
        join
        idle(4);
        expect_pair(2, 32'hC200, 3, 32'hD200, 4, "R4 dat-first pair", pos);
        expect_count(2, 7, "R2 port2 beat count");
    endtask

    // R4: both arrive together
    task automatic t_together();
        int pos = 0;
        clear_logs();
        fork
            send_dat(4'd3, 32'hD300, 2, 1'b0, 4'd0);
            send_ctl(32'hC300, 1);
        join
        idle(4);
        expect_pair(3, 32'hC300, 1, 32'hD300, 2, "R4 simultaneous pair", pos);
    endtask

    // R6: TDEST changes after first beat
    task automatic t_dest_change();
        int pos = 0;
        clear_logs();
        fork
            send_dat(4'd2, 32'hD400, 3, 1'b1, 4'd0);
            send_ctl(32'hC400, 1);
        join
        idle(4);
        expect_pair(2, 32'hC400, 1, 32'hD400, 3, "R6 first-beat dest kept", pos);
        expect_count(0, 0, "R6 later dest ignored");
    endtask

    // R7 R9: out-of-range destination then a normal pair
    task automatic t_drop();
        int pos = 0;
        clear_logs();
        fork
            begin send_ctl(32'hC500, 2); send_ctl(32'hC510, 1); end
            begin send_dat(4'd9, 32'hD500, 3, 1'b0, 4'd0); send_dat(4'd0, 32'hD510, 2, 1'b0, 4'd0); end
        join
        idle(4);
        expect_pair(0, 32'hC510, 1, 32'hD510, 2, "R7 pair after drop", pos);
        expect_count(0, 3, "R7 nothing of dropped pair");
        expect_count(1, 0, "R7 port1 silent");
        expect_count(2, 0, "R7 port2 silent");
        expect_count(3, 0, "R7 port3 silent");
    endtask

    // R9: several pairs in order
    task automatic t_in_order();
        int pos3 = 0;
        int pos0 = 0;
        clear_logs();
        fork
            begin send_ctl(32'hC600, 2); send_ctl(32'hC610, 1); send_ctl(32'hC620, 3); end
            begin send_dat(4'd3, 32'hD600, 1, 1'b0, 4'd0);
                  send_dat(4'd0, 32'hD610, 2, 1'b0, 4'd0);
                  send_dat(4'd3, 32'hD620, 2, 1'b0, 4'd0); end
        join
        idle(4);
        expect_pair(3, 32'hC600, 2, 32'hD600, 1, "R9 first pair", pos3);
        expect_pair(0, 32'hC610, 1, 32'hD610, 2, "R9 second pair", pos0);
        expect_pair(3, 32'hC620, 3, 32'hD620, 2, "R9 third pair", pos3);
    endtask

    // R8: backpressure on selected data port
    task automatic t_backpressure();
        int pos = 0;
        clear_logs();
        m_dat_tready[1] = 1'b0;
        fork
            send_dat(4'd1, 32'hD700, 3, 1'b0, 4'd0);
            send_ctl(32'hC700, 1);
            begin
                logic [DW-1:0] held;
                @(negedge clk);
                while (!m_dat_tvalid[1]) @(negedge clk);
                held = m_dat_tdata[1*DW +: DW];
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk(m_dat_tvalid[1], "R8 valid held", m_dat_tvalid[1], 1);
                    chk(m_dat_tdata[1*DW +: DW] == held, "R8 data stable", m_dat_tdata[1*DW +: DW], held);
                    chk(!s_dat_tready, "R8 input stalled", s_dat_tready, 0);
                end
                @(posedge clk); #1;
                m_dat_tready[1] = 1'b1;
            end
        join
        idle(4);
        expect_pair(1, 32'hC700, 1, 32'hD700, 3, "R8 pair intact", pos);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        clear_logs();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_ctl_first();
        t_dat_first();
        t_together();
        t_dest_change();
        t_drop();
        t_in_order();
        t_backpressure();
        summary();
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 50000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                summary();
            end
        end
    end

endmodule